// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synchronous static RAM with a pipelined read path. It is meant for a cache or buffer whose controller drives the usual synchronous-SRAM handshake. The common bidirectional data bus is split into three signals: a write-data input, a read-data output and a drive-enable. The pad ring or a wrapper turns these into a three-state pin. The array holds `DEPTH` words of 36 bits. Each word has four lanes of 9 bits, and lane `i` occupies bits `9*i+8 : 9*i`.

Every control input is sampled on the rising clock edge. Either of two address strobes starts an access.
- The processor strobe always starts a read. A write that follows it is taken on the next clock, at the address already held.
- The controller strobe writes in the same cycle when the write inputs are active.

Once an access has started, a clock with no strobe continues it at the held address. That clock is a write when the write inputs are active and a read otherwise. Read data passes through an output register.

The drive-enable is gated in three cases:
- On the first read after a deselect or after reset.
- After any write.
- When output enable is high. This gate is combinational.

Top module: `pipe_sync_sram`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at a strobe edge. A recognized strobe edge without that selection deselects the device, and `rdata_oe_o` is low right after that edge. While deselected, a clock with no recognized strobe performs no read and no write.
- R2: A low `proc_strb_n` is ignored while `sel_a_n` is high. With `ctrl_strb_n` high, such a clock continues the current access at the held address and does not load `addr_i`.
- R3: When both strobes are low and `sel_a_n` is low, only the processor strobe is recognized, so the cycle is a read and no write takes place.
- R4: A processor-strobe cycle is a read whatever the write inputs are. A write for that address happens on a later strobe-free clock whose write inputs are active.
- R5: A controller-strobe cycle with active write inputs writes `wdata_i` to `addr_i` at that same edge.
- R6: `wr_all_n`=0 writes all four lanes. Otherwise lane `i` is written only when `wr_byte_n`=0 and `lane_sel_n[i]`=0. Lanes that are not written keep their contents.
- R7: Data for an address captured at edge N is on `rdata_o` after edge N+1. Back-to-back reads deliver one word per clock.
- R8: On the first read after a deselect or reset, `rdata_oe_o` stays low after the data edge. On the next continuing read clock it goes high.
- R9: A write cycle forces `rdata_oe_o` low after that edge, regardless of output enable. It stays low through strobe-free read clocks until a strobe starts a new read.
- R10: `out_en_n` high forces `rdata_oe_o` low combinationally, without waiting for a clock.
- R11: After reset `rdata_oe_o` is low and the device is in the deselected state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | $clog2(DEPTH) | Word address, captured by a recognized, selected strobe |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, combinational |
| wdata_i | input | 36 | Write data |
| rdata_o | output | 36 | Registered read data |
| rdata_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The assertions check four gating rules on every clock:
- Output enable gating of the drive-enable.
- Tri-stating after a write edge.
- Tri-stating after a deselect edge.
- The mask on the first read after a deselect.

On every clock they also check that a recognized processor strobe never raises a lane write enable, and that a processor strobe gated off by select A never starts or ends an access. Some behaviour only the directed scenarios can show:
- Stored contents and lane merging.
- The one-clock read latency on back-to-back reads.
- The two-clock write after a processor strobe.
- Writes being ignored while the device is deselected.

The directed scenarios compare every read with a reference array that the bench keeps itself.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned SRAM_LANES  = 4;
  localparam int unsigned SRAM_LANE_W = 9;
  localparam int unsigned SRAM_WORD_W = SRAM_LANES * SRAM_LANE_W;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_RD_NEW,
    CYC_RD_CONT,
    CYC_WRITE
  } cyc_e;

  // All three selects at their active level.
  function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  // Lanes that a write would touch for a given set of write inputs.
  function automatic logic [SRAM_LANES-1:0] lane_mask(input logic all_n, input logic byte_n,
                                                     input logic [SRAM_LANES-1:0] sel_n);
    if (!all_n) return '1;
    if (!byte_n) return ~sel_n;
    return '0;
  endfunction
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_pkg::*;
(
  input  logic                  proc_strb_n,
  input  logic                  ctrl_strb_n,
  input  logic                  sel_a_n,
  input  logic                  sel_b,
  input  logic                  sel_c_n,
  input  logic                  wr_all_n,
  input  logic                  wr_byte_n,
  input  logic [SRAM_LANES-1:0] lane_sel_n,
  input  logic                  active_i,
  output cyc_e                  kind_o,
  output logic                  start_o,
  output logic [SRAM_LANES-1:0] lane_we_o
);
  logic                  proc_rec;
  logic                  ctrl_rec;
  logic                  selected;
  logic [SRAM_LANES-1:0] mask;
  logic                  wr_req;

  assign proc_rec = !proc_strb_n && !sel_a_n;
  assign ctrl_rec = !proc_rec && !ctrl_strb_n;
  assign selected = chip_selected(sel_a_n, sel_b, sel_c_n);
  assign mask     = lane_mask(wr_all_n, wr_byte_n, lane_sel_n);
  assign wr_req   = |mask;

  always_comb begin
    if (proc_rec)      kind_o = selected ? CYC_RD_NEW : CYC_DESEL;
    else if (ctrl_rec) kind_o = !selected ? CYC_DESEL : (wr_req ? CYC_WRITE : CYC_RD_NEW);
    else if (active_i) kind_o = wr_req ? CYC_WRITE : CYC_RD_CONT;
    else               kind_o = CYC_IDLE;
  end

  assign start_o   = (proc_rec || ctrl_rec) && selected;
  assign lane_we_o = (kind_o == CYC_WRITE) ? mask : '0;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LW
) (
  input  logic             clk,
  input  logic [LANES-1:0] we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [AW-1:0]    raddr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LW +: LW];
    end
    assign rdata_o[g*LW +: LW] = mem[raddr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
#(
  parameter int unsigned DW = SRAM_WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          kind_i,
  input  logic          active_i,
  input  logic          wr_hold_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          out_en_n,
  output logic [DW-1:0] dout_o,
  output logic          doe_o
);
  logic pend_vld_q;
  logic pend_en_q;
  logic drv_q;
  logic kill;

  // A write or a deselect at this edge blanks the word that is leaving the pipe.
  assign kill = (kind_i == CYC_WRITE) || (kind_i == CYC_DESEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      pend_en_q  <= 1'b0;
      drv_q      <= 1'b0;
      dout_o     <= '0;
    end else begin
      pend_vld_q <= (kind_i == CYC_RD_NEW) || (kind_i == CYC_RD_CONT);
      pend_en_q  <= (kind_i == CYC_RD_NEW) ? active_i : !wr_hold_i;
      if (pend_vld_q) dout_o <= rdata_i;
      drv_q      <= pend_vld_q && pend_en_q && !kill;
    end
  end

  assign doe_o = drv_q && !out_en_n;
endmodule

// File: rtl/pipe_sync_sram.sv
module pipe_sync_sram
  import sram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = SRAM_WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr_i,
  input  logic                  proc_strb_n,
  input  logic                  ctrl_strb_n,
  input  logic                  sel_a_n,
  input  logic                  sel_b,
  input  logic                  sel_c_n,
  input  logic                  wr_all_n,
  input  logic                  wr_byte_n,
  input  logic [SRAM_LANES-1:0] lane_sel_n,
  input  logic                  out_en_n,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output logic                  rdata_oe_o
);
  cyc_e                  kind;
  logic                  start;
  logic [SRAM_LANES-1:0] lane_we;
  logic                  active_q;
  logic                  wr_hold_q;
  logic [AW-1:0]         addr_q;
  logic [AW-1:0]         waddr;
  logic [DW-1:0]         arr_rdata;

  // Named events for the checker.
  logic ev_write, ev_desel, ev_rd_new;
  assign ev_write  = (kind == CYC_WRITE);
  assign ev_desel  = (kind == CYC_DESEL);
  assign ev_rd_new = (kind == CYC_RD_NEW);

  sram_cycle_decode u_dec (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .wr_all_n    (wr_all_n),
    .wr_byte_n   (wr_byte_n),
    .lane_sel_n  (lane_sel_n),
    .active_i    (active_q),
    .kind_o      (kind),
    .start_o     (start),
    .lane_we_o   (lane_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      wr_hold_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      if (start) addr_q <= addr_i;
      if (ev_desel)      active_q <= 1'b0;
      else if (start)    active_q <= 1'b1;
      if (ev_write)                 wr_hold_q <= 1'b1;
      else if (ev_rd_new || ev_desel) wr_hold_q <= 1'b0;
    end
  end

  // A write that opens an access uses the address on the pins; a continuation uses the held one.
  assign waddr = start ? addr_i : addr_q;

  sram_lane_array #(
    .DEPTH (DEPTH),
    .LANES (SRAM_LANES),
    .LW    (SRAM_LANE_W)
  ) u_arr (
    .clk     (clk),
    .we_i    (lane_we),
    .waddr_i (waddr),
    .raddr_i (addr_q),
    .wdata_i (wdata_i),
    .rdata_o (arr_rdata)
  );

  sram_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind_i    (kind),
    .active_i  (active_q),
    .wr_hold_i (wr_hold_q),
    .rdata_i   (arr_rdata),
    .out_en_n  (out_en_n),
    .dout_o    (rdata_o),
    .doe_o     (rdata_oe_o)
  );
endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_en_n,
  input logic             proc_strb_n,
  input logic             ctrl_strb_n,
  input logic             sel_a_n,
  input logic             rdata_oe_o,
  input logic             ev_write,
  input logic             ev_desel,
  input logic             ev_rd_new,
  input logic             active_q,
  input logic [LANES-1:0] lane_we
);
  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n) ev_desel |=> !rdata_oe_o); // R1
  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && sel_a_n && ctrl_strb_n) |-> (!ev_rd_new && !ev_desel)); // R2
  AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && !sel_a_n) |-> (lane_we == '0)); // R4
  AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_new && !active_q) |=> ##1 !rdata_oe_o); // R8
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n) ev_write |=> !rdata_oe_o); // R9
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n) out_en_n |-> !rdata_oe_o); // R10
endmodule

bind pipe_sync_sram sram_burst_chk #(.LANES(sram_pkg::SRAM_LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_en_n    (out_en_n),
  .proc_strb_n (proc_strb_n),
  .ctrl_strb_n (ctrl_strb_n),
  .sel_a_n     (sel_a_n),
  .rdata_oe_o  (rdata_oe_o),
  .ev_write    (ev_write),
  .ev_desel    (ev_desel),
  .ev_rd_new   (ev_rd_new),
  .active_q    (active_q),
  .lane_we     (lane_we)
);

// File: tb/pipe_sync_sram_tb.sv
`timescale 1ns/1ps
module pipe_sync_sram_tb_top;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          proc_strb_n, ctrl_strb_n, sel_a_n, sel_b, sel_c_n;
  logic          wr_all_n, wr_byte_n, out_en_n;
  logic [3:0]    lane_sel_n;
  logic [35:0]   wdata_i, rdata_o;
  logic          rdata_oe_o;

  logic [35:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pipe_sync_sram #(.DEPTH(DEPTH)) dut_i (.*);

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d,
                                        input logic all_n, input logic byte_n, input logic [3:0] sel_n);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!all_n || (!byte_n && !sel_n[i])) r[i*9 +: 9] = d[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(input string rq, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, got, exp);
    end
  endtask

  task automatic idle();
    proc_strb_n = 1; ctrl_strb_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_sel_n = 4'hF; wdata_i = '0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ctrl_write(input logic [AW-1:0] a, input logic [35:0] d,
                            input logic wa, input logic wb, input logic [3:0] bs);
    idle(); ctrl_strb_n = 0; addr_i = a; wdata_i = d; wr_all_n = wa; wr_byte_n = wb; lane_sel_n = bs;
    tick();
    ref_mem[a] = merge(ref_mem[a], d, wa, wb, bs);
    idle();
  endtask

  task automatic proc_read(input logic [AW-1:0] a);
    idle(); proc_strb_n = 0; addr_i = a;
    tick();
    idle();
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string rq);
    proc_read(a);
    tick();
    chk(rq, rdata_o, ref_mem[a]);
    chk(rq, {35'd0, rdata_oe_o}, 36'd1);
  endtask

  task automatic t_reset();
    chk("R11 drive low after reset", {35'd0, rdata_oe_o}, 36'd0);
  endtask

  task automatic t_ctrl_write_read();
    ctrl_write(8'h10, 36'h1_2345_6789, 0, 1, 4'hF);
    chk("R9 write blanks bus", {35'd0, rdata_oe_o}, 36'd0);
    ctrl_write(8'h11, 36'hA_BCDE_F012, 0, 1, 4'hF);
    ctrl_write(8'h12, 36'h5_5555_5555, 0, 1, 4'hF);
    ctrl_write(8'h40, 36'h0_0F0F_0F0F, 0, 1, 4'hF);
    proc_read(8'h10);
    chk("R9 hold until read data", {35'd0, rdata_oe_o}, 36'd0);
    tick();
    chk("R5 same-cycle write", rdata_o, ref_mem[8'h10]);
    chk("R7 driven", {35'd0, rdata_oe_o}, 36'd1);
    proc_read(8'h11);
    proc_read(8'h12);
    chk("R7 one-clock latency", rdata_o, ref_mem[8'h11]);
    tick();
    chk("R7 back-to-back", rdata_o, ref_mem[8'h12]);
  endtask

  task automatic t_lanes();
    ctrl_write(8'h12, 36'h0_0000_0000, 1, 0, 4'b1010);
    read_check(8'h12, "R6 lanes 0 and 2");
    ctrl_write(8'h12, 36'hF_FFFF_FFFF, 1, 1, 4'h0);
    read_check(8'h12, "R6 no lane without byte enable");
    ctrl_write(8'h12, 36'h9_8765_4321, 0, 1, 4'hF);
    read_check(8'h12, "R6 all-lane override");
  endtask

  task automatic t_proc_two_cycle();
    idle(); proc_strb_n = 0; ctrl_strb_n = 0; addr_i = 8'h11; wr_all_n = 0; wdata_i = 36'h3_3333_3333;
    tick();
    idle(); tick();
    chk("R3 both strobes read old data", rdata_o, ref_mem[8'h11]);
    chk("R4 first cycle is a read", {35'd0, rdata_oe_o}, 36'd1);
    wr_all_n = 0; wdata_i = 36'h3_3333_3333;
    tick();
    ref_mem[8'h11] = 36'h3_3333_3333;
    chk("R9 write forces hi-z", {35'd0, rdata_oe_o}, 36'd0);
    idle(); tick();
    chk("R9 stays hi-z without strobe", {35'd0, rdata_oe_o}, 36'd0);
    read_check(8'h11, "R4 second-cycle write");
  endtask

  task automatic t_sel_a_gate();
    idle(); proc_strb_n = 0; sel_a_n = 1; addr_i = 8'h40; wr_all_n = 0; wdata_i = 36'h7_0000_0007;
    tick();
    ref_mem[8'h11] = 36'h7_0000_0007;
    idle();
    read_check(8'h11, "R2 held address written");
    read_check(8'h40, "R2 new address untouched");
  endtask

  task automatic t_deselect();
    idle(); proc_strb_n = 0; sel_c_n = 1;
    tick();
    chk("R1 deselect hi-z", {35'd0, rdata_oe_o}, 36'd0);
    idle(); ctrl_strb_n = 0; sel_b = 0;
    tick();
    chk("R1 deselect via ctrl strobe", {35'd0, rdata_oe_o}, 36'd0);
    idle(); addr_i = 8'h10; wr_all_n = 0; wdata_i = 36'hE_EEEE_EEEE;
    tick();
    idle();
    proc_read(8'h10);
    tick();
    chk("R1 no write while deselected", rdata_o, ref_mem[8'h10]);
    chk("R8 first read masked", {35'd0, rdata_oe_o}, 36'd0);
    tick();
    chk("R8 next read driven", {35'd0, rdata_oe_o}, 36'd1);
  endtask

  task automatic t_oe();
    out_en_n = 1; #1;
    chk("R10 oe high blanks", {35'd0, rdata_oe_o}, 36'd0);
    out_en_n = 0; #1;
    chk("R10 oe low drives", {35'd0, rdata_oe_o}, 36'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; addr_i = '0; out_en_n = 0; idle();
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_ctrl_write_read();
    t_lanes();
    t_proc_two_cycle();
    t_sel_a_gate();
    t_deselect();
    t_oe();
    tick();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule